// File: doc/BRIEF.md
# ADC Result and Status Holding Register

This block sits in the digital back end of a multichannel sigma-delta converter. Each time the filter delivers a conversion, it presents a result-write strobe with a 24-bit data word, the tag of the channel that produced it, and flags for overrange, underrange and low reference. The block conditions the word by clamping and parity and stores it. It also keeps an 8-bit read-only status word that holds a data-ready flag, an error flag, a missing-reference flag, a parity bit and the source-channel tag.

A host reads through a simple strobe-and-select port that stands in for the serial front end. Select code 3'b000 returns the status word and select code 3'b011 returns the stored result. An optional mode appends the status byte after the data word on every data read. Each read answer is left-aligned in a 32-bit output with a bit count, so a shifter can send it MSB first.

The ready flag has low-true meaning: 0 says that an unread result is waiting. It returns to 1 when the result is consumed, when a new result is close, or when the converter is stopped.

Top module: `adc_result_status`

## Requirements
- R1: After reset the status word is 0x80 (only RDY set), the stored result is zero and `rd_valid` is low.
- R2: The status word bits are [7] RDY, [6] ERR, [5] NOREF, [4] parity, [3:0] channel tag. A read with `rd_sel`=3'b000 gives `rd_valid` high in the cycle after the strobe, `rd_dout`={status, 24'b0} and `rd_len`=8.
- R3: A result write clears RDY and stores the conditioned word and the channel tag supplied with that write. The tag records the channel of the stored result.
- R4: A data read (`rd_sel`=3'b011) with append off returns {result, 8'b0} with `rd_len`=24. If RDY was clear, RDY becomes set.
- R5: A data read while RDY is set returns the stored result and leaves every status bit unchanged.
- R6: While `wr_eta` is in 1..PRE_RDY_CYC (default 4), RDY is set. A value of 0 or above the limit has no effect.
- R7: While `pwr_down` is high, `idle` is high or `sync_n` is low, RDY is forced set. This also holds in a cycle with a result write.
- R8: On a write with overrange, the result is stored as all ones and ERR is set. On a write with underrange and no overrange, the result is stored as all zeros and ERR is set. A later in-range write clears ERR and stores the word unchanged.
- R9: When `refdet_en` is high and `ref_low` is high on a write, NOREF and ERR are set and the result is stored as all ones. When `refdet_en` is low, `ref_low` is ignored.
- R10: When `parity_en` is high on a write, the parity bit is 1 for an odd number of ones in the stored result and 0 for an even number. When `parity_en` is low, the parity bit is 0.
- R11: With `append_en` high, a data read returns {result, status} with `rd_len`=32. The status is the value from before the read.
- R12: When a result write and a data read fall in the same cycle, the read returns the old result and old status. The new result is stored and RDY ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_wr | input | 1 | Result write strobe |
| res_data | input | 24 | Raw conversion word |
| res_chan | input | 4 | Channel that produced the word |
| res_over | input | 1 | Word is over range |
| res_under | input | 1 | Word is under range |
| ref_low | input | 1 | Selected reference below threshold |
| refdet_en | input | 1 | Reference detection enable |
| parity_en | input | 1 | Parity bit enable |
| append_en | input | 1 | Append status to data reads |
| wr_eta | input | 8 | Cycles until the next scheduled result write, 0 if none |
| pwr_down | input | 1 | Converter powered down |
| idle | input | 1 | Converter in idle mode |
| sync_n | input | 1 | Active-low synchronisation input |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 3 | Register select |
| rd_valid | output | 1 | Read answer valid |
| rd_dout | output | 32 | Left-aligned read answer |
| rd_len | output | 6 | Number of valid bits in rd_dout |

## Verification
A result write and a host data read can land in the same clock cycle. One changes the stored word and clears RDY, and the other wants the word and wants RDY set. The bench provokes this by asserting `res_wr` and a data-select `rd_stb` on the same edge, after a first result is already waiting. It judges the answer against the earlier result, checks by a status read that RDY is clear and the new channel tag is present, and checks by a later data read that the new word was kept. A forced-ready condition that coincides with a write is exercised the same way.

// File: rtl/ars_pkg.sv
package ars_pkg;
    localparam int STAT_W = 8;
    localparam int TAG_W  = 4;

    localparam logic [2:0] SEL_STATUS = 3'b000;
    localparam logic [2:0] SEL_RESULT = 3'b011;

    typedef struct packed {
        logic             rdy;
        logic             err;
        logic             noref;
        logic             par;
        logic [TAG_W-1:0] tag;
    } stat_t;

    localparam stat_t STAT_RST = stat_t'(8'h80);
endpackage

// File: rtl/ars_clamp.sv
module ars_clamp #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              over_i,
    input  logic              under_i,
    input  logic              ref_low_i,
    input  logic              refdet_en_i,
    input  logic              par_en_i,
    output logic [DATA_W-1:0] res_o,
    output logic              err_o,
    output logic              noref_o,
    output logic              par_o
);
    logic ref_bad;

    always_comb begin
        ref_bad = ref_low_i && refdet_en_i;
        res_o   = raw_i;
        err_o   = 1'b0;
        if (ref_bad || over_i) begin
            res_o = {DATA_W{1'b1}};
            err_o = 1'b1;
        end else if (under_i) begin
            res_o = '0;
            err_o = 1'b1;
        end
        noref_o = ref_bad;
        par_o   = par_en_i && (^res_o);
    end
endmodule

// File: rtl/ars_status.sv
module ars_status
    import ars_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int PRE_RDY_CYC = 4,
    parameter int ETA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              err_i,
    input  logic              noref_i,
    input  logic              par_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              consume_i,
    input  logic              force_i,
    input  logic [ETA_W-1:0]  eta_i,
    output stat_t             stat_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [ETA_W-1:0] ETA_LIM = ETA_W'(PRE_RDY_CYC);

    typedef struct packed {
        stat_t             stat;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  eta_win;

    always_comb begin
        eta_win = (eta_i != '0) && (eta_i <= ETA_LIM);
        hold_d  = hold_q;
        if (consume_i && !hold_q.stat.rdy) hold_d.stat.rdy = 1'b1;
        if (eta_win)                       hold_d.stat.rdy = 1'b1;
        if (wr_i) begin
            hold_d.data       = res_i;
            hold_d.stat.rdy   = 1'b0;
            hold_d.stat.err   = err_i;
            hold_d.stat.noref = noref_i;
            hold_d.stat.par   = par_i;
            hold_d.stat.tag   = tag_i;
        end
        if (force_i) hold_d.stat.rdy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q.stat <= STAT_RST;
            hold_q.data <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign stat_o = hold_q.stat;
    assign data_o = hold_q.data;

    // R3
    wr_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !force_i |=> !stat_o.rdy && stat_o.tag == $past(tag_i));
    // R7
    force_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> stat_o.rdy);
    // R4
    consume_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i && !stat_o.rdy && !wr_i |=> stat_o.rdy);
    // R5
    busy_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i && stat_o.rdy && !wr_i |=> $stable(stat_o) && $stable(data_o));
endmodule

// File: rtl/ars_readout.sv
module ars_readout
    import ars_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [2:0]        sel_i,
    input  logic              append_i,
    input  stat_t             stat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W+STAT_W-1:0] dout_o,
    output logic [$clog2(DATA_W+STAT_W+1)-1:0] len_o
);
    localparam int OUT_W = DATA_W + STAT_W;
    localparam int LEN_W = $clog2(OUT_W + 1);

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] dout;
        logic [LEN_W-1:0] len;
    } ans_t;

    ans_t ans_d, ans_q;

    always_comb begin
        ans_d.valid = rd_i;
        ans_d.dout  = '0;
        ans_d.len   = '0;
        if (rd_i) begin
            if (sel_i == SEL_STATUS) begin
                ans_d.dout = {stat_i, {DATA_W{1'b0}}};
                ans_d.len  = LEN_W'(STAT_W);
            end else if (sel_i == SEL_RESULT) begin
                if (append_i) begin
                    ans_d.dout = {data_i, stat_i};
                    ans_d.len  = LEN_W'(OUT_W);
                end else begin
                    ans_d.dout = {data_i, {STAT_W{1'b0}}};
                    ans_d.len  = LEN_W'(DATA_W);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ans_q <= '0;
        else        ans_q <= ans_d;
    end

    assign valid_o = ans_q.valid;
    assign dout_o  = ans_q.dout;
    assign len_o   = ans_q.len;

    // R2
    answer_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> valid_o);
    // R11
    append_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && sel_i == SEL_RESULT && append_i |=> len_o == LEN_W'(OUT_W));
endmodule

// File: rtl/adc_result_status.sv
module adc_result_status
    import ars_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int PRE_RDY_CYC = 4,
    parameter int ETA_W       = 8,
    localparam int OUT_W      = DATA_W + STAT_W,
    localparam int LEN_W      = $clog2(OUT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_wr,
    input  logic [DATA_W-1:0] res_data,
    input  logic [3:0]        res_chan,
    input  logic              res_over,
    input  logic              res_under,
    input  logic              ref_low,
    input  logic              refdet_en,
    input  logic              parity_en,
    input  logic              append_en,
    input  logic [ETA_W-1:0]  wr_eta,
    input  logic              pwr_down,
    input  logic              idle,
    input  logic              sync_n,
    input  logic              rd_stb,
    input  logic [2:0]        rd_sel,
    output logic              rd_valid,
    output logic [OUT_W-1:0]  rd_dout,
    output logic [LEN_W-1:0]  rd_len
);
    logic [DATA_W-1:0] cond_res;
    logic              cond_err, cond_noref, cond_par;
    logic              hold_force, data_rd;
    stat_t             stat_w;
    logic [DATA_W-1:0] data_w;

    assign hold_force = pwr_down || idle || !sync_n;
    assign data_rd    = rd_stb && (rd_sel == SEL_RESULT);

    ars_clamp #(.DATA_W(DATA_W)) u_clamp (
        .raw_i(res_data), .over_i(res_over), .under_i(res_under),
        .ref_low_i(ref_low), .refdet_en_i(refdet_en), .par_en_i(parity_en),
        .res_o(cond_res), .err_o(cond_err), .noref_o(cond_noref), .par_o(cond_par)
    );

    ars_status #(.DATA_W(DATA_W), .PRE_RDY_CYC(PRE_RDY_CYC), .ETA_W(ETA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_i(res_wr), .res_i(cond_res),
        .err_i(cond_err), .noref_i(cond_noref), .par_i(cond_par), .tag_i(res_chan),
        .consume_i(data_rd), .force_i(hold_force), .eta_i(wr_eta),
        .stat_o(stat_w), .data_o(data_w)
    );

    ars_readout #(.DATA_W(DATA_W)) u_readout (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_stb), .sel_i(rd_sel),
        .append_i(append_en), .stat_i(stat_w), .data_i(data_w),
        .valid_o(rd_valid), .dout_o(rd_dout), .len_o(rd_len)
    );

    // R10
    parity_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr && parity_en |=> stat_w.par == ($countones(data_w) % 2 == 1));
    // R10
    parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr && !parity_en |=> !stat_w.par);
    // R9
    noref_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr && ref_low && refdet_en |=> stat_w.noref && stat_w.err && (&data_w));
    // R8
    over_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr && res_over |=> stat_w.err && (&data_w));
    // R8
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr && !res_over && !res_under && !(ref_low && refdet_en)
        |=> !stat_w.err && data_w == $past(res_data));
endmodule

// File: tb/adc_result_status_bench.sv
`timescale 1ns/1ps
module adc_result_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_wr = 0, res_over = 0, res_under = 0, ref_low = 0;
    logic        refdet_en = 0, parity_en = 0, append_en = 0;
    logic        pwr_down = 0, idle = 0, sync_n = 1, rd_stb = 0;
    logic [23:0] res_data = '0;
    logic [3:0]  res_chan = '0;
    logic [7:0]  wr_eta = '0;
    logic [2:0]  rd_sel = '0;
    logic        rd_valid;
    logic [31:0] rd_dout;
    logic [5:0]  rd_len;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    adc_result_status u_adc_result_status (
        .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_data(res_data),
        .res_chan(res_chan), .res_over(res_over), .res_under(res_under),
        .ref_low(ref_low), .refdet_en(refdet_en), .parity_en(parity_en),
        .append_en(append_en), .wr_eta(wr_eta), .pwr_down(pwr_down), .idle(idle),
        .sync_n(sync_n), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_valid(rd_valid),
        .rd_dout(rd_dout), .rd_len(rd_len)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic write(logic [23:0] d, logic [3:0] ch, logic ov, logic un);
        res_wr = 1; res_data = d; res_chan = ch; res_over = ov; res_under = un;
        tick();
        res_wr = 0; res_over = 0; res_under = 0;
    endtask

    task automatic read(logic [2:0] sel);
        rd_stb = 1; rd_sel = sel;
        tick();
        rd_stb = 0;
    endtask

    task automatic expect_status(string req, logic [7:0] s);
        read(3'b000);
        chk(req, rd_dout, {s, 24'h0});
        chk(req, 32'(rd_len), 32'd8);
    endtask

    task automatic expect_data(string req, logic [31:0] v, logic [5:0] n);
        read(3'b011);
        chk(req, rd_dout, v);
        chk(req, 32'(rd_len), 32'(n));
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(rd_valid), 32'd0);
        expect_status("R1 R2", 8'h80);
        chk("R2 valid", 32'(rd_valid), 32'd1);
        expect_data("R1 data", 32'h0, 6'd24);
    endtask

    task automatic t_write_read();
        write(24'h123456, 4'd5, 0, 0);
        expect_status("R3", 8'h05);
        expect_data("R4", 32'h12345600, 6'd24);
        expect_status("R4 rdy", 8'h85);
    endtask

    task automatic t_busy_read();
        expect_data("R5 data", 32'h12345600, 6'd24);
        expect_status("R5 stat", 8'h85);
    endtask

    task automatic t_clamp();
        write(24'h000100, 4'd2, 1, 0);
        expect_status("R8 over", 8'h42);
        expect_data("R8 ones", 32'hFFFFFF00, 6'd24);
        write(24'h000100, 4'd3, 0, 1);
        expect_status("R8 under", 8'h43);
        expect_data("R8 zeros", 32'h00000000, 6'd24);
        write(24'h00ABCD, 4'd1, 0, 0);
        expect_status("R8 clear", 8'h01);
        expect_data("R8 pass", 32'h00ABCD00, 6'd24);
    endtask

    task automatic t_noref();
        refdet_en = 1; ref_low = 1;
        write(24'h000010, 4'd4, 0, 0);
        expect_status("R9 set", 8'h64);
        expect_data("R9 ones", 32'hFFFFFF00, 6'd24);
        refdet_en = 0;
        write(24'h000010, 4'd4, 0, 0);
        expect_status("R9 ignored", 8'h04);
        expect_data("R9 ignored data", 32'h00001000, 6'd24);
        ref_low = 0;
    endtask

    task automatic t_parity();
        parity_en = 1;
        write(24'h000007, 4'd0, 0, 0);
        expect_status("R10 odd", 8'h10);
        write(24'h000003, 4'd0, 0, 0);
        expect_status("R10 even", 8'h00);
        parity_en = 0;
        write(24'h000007, 4'd0, 0, 0);
        expect_status("R10 off", 8'h00);
    endtask

    task automatic t_append();
        append_en = 1;
        write(24'h00A5A5, 4'd9, 0, 0);
        expect_data("R11", 32'h00A5A509, 6'd32);
        expect_status("R11 after", 8'h89);
        append_en = 0;
    endtask

    task automatic t_pre_update();
        write(24'h000001, 4'd6, 0, 0);
        wr_eta = 8'd5;
        tick();
        expect_status("R6 above", 8'h06);
        wr_eta = 8'd4;
        tick();
        wr_eta = 8'd0;
        expect_status("R6 window", 8'h86);
    endtask

    task automatic t_force();
        write(24'h000002, 4'd7, 0, 0);
        pwr_down = 1; tick(); pwr_down = 0;
        expect_status("R7 pwr_down", 8'h87);
        write(24'h000002, 4'd7, 0, 0);
        idle = 1; tick(); idle = 0;
        expect_status("R7 idle", 8'h87);
        sync_n = 0;
        write(24'h000002, 4'd8, 0, 0);
        sync_n = 1;
        expect_status("R7 sync with write", 8'h88);
    endtask

    task automatic t_collision();
        write(24'h0000AA, 4'd1, 0, 0);
        res_wr = 1; res_data = 24'h0000BB; res_chan = 4'd2;
        rd_stb = 1; rd_sel = 3'b011;
        tick();
        res_wr = 0; rd_stb = 0;
        chk("R12 old data", rd_dout, 32'h0000AA00);
        expect_status("R12 stat", 8'h02);
        expect_data("R12 new data", 32'h0000BB00, 6'd24);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_write_read();
        t_busy_read();
        t_clamp();
        t_noref();
        t_parity();
        t_append();
        t_pre_update();
        t_force();
        t_collision();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule